// File: doc/BRIEF.md
# Dual-Channel Serial DAC Input Register

This block is the digital front end of a stereo audio converter that accepts its samples serially. A left and a right serial data line share one serial bit clock. Every rising edge of that bit clock pushes one bit into a per-channel shift register. The shift register never stops and counts nothing. Each channel also has its own active-low load line. When a load line falls, the 18 bits most recently shifted into that channel move to the channel's parallel output register. A one-cycle update strobe marks the move.

All five serial-side inputs are asynchronous to the block clock. They go through a two-flop synchroniser, and the edges are then found in the block clock domain. The block clock must run at least four times as fast as the serial bit clock. The outputs are 18-bit two's-complement codes, sent MSB first on the wire. After reset each output holds the midscale code, which is zero.

Top module: `serial_dac_frontend`

## Requirements
- R1: After reset, both output codes equal 18'h00000 (midscale) and both update strobes are low until that channel's first load falling edge.
- R2: Serial words are taken MSB first. After exactly 18 bit-clock rising edges followed by a load falling edge, the code equals the 18 bits in order of arrival, with the first bit at bit 17.
- R3: When more than 18 bits arrive between loads, only the final 18 appear in the code.
- R4: When fewer than 18 bits (n) arrive after a previous word, the code holds the older bits shifted up by n, with the n new bits in the low positions.
- R5: A load on one channel leaves the other channel's code and strobe unchanged.
- R6: When both load lines fall together, both strobes assert in the same clock cycle. When both data lines carry the same stream, both codes are equal.
- R7: An update strobe is a single-cycle pulse that occurs only on a load falling edge. A rising edge on a load line, or a load line held low, causes no further update.
- R8: A data line that changes while the bit clock has no rising edge has no effect on the word shifted in.
- R9: Words are received correctly with a bit clock period of four block-clock cycles (two high, two low).
- R10: The code and strobe change on the third block-clock rising edge after the load line falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Shared serial bit clock (asynchronous) |
| ldata_i | input | 1 | Left serial data |
| rdata_i | input | 1 | Right serial data |
| lload_n_i | input | 1 | Left load, falling edge transfers word |
| rload_n_i | input | 1 | Right load, falling edge transfers word |
| lcode_o | output | 18 | Left output code, two's complement |
| rcode_o | output | 18 | Right output code, two's complement |
| lupd_o | output | 1 | Left update strobe, one cycle |
| rupd_o | output | 1 | Right update strobe, one cycle |

## Verification
The hardest case to reach from the ports is a short word: a load that follows fewer than 18 bits. The code then mixes the tail of an earlier word with the new bits, so the bench must remember the whole stream history of each channel. For this, the bench keeps a running model of each channel's shift register, updated on every bit-clock rise it drives. It first loads a full word, then sends 6 bits and loads again. Shared-load alignment and load latency are measured by counting block-clock cycles from the driven load edge to the observed strobe.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
    localparam int NUM_CH   = 2;
    localparam int CH_LEFT  = 0;
    localparam int CH_RIGHT = 1;
    // positions in the synchronised input bus
    localparam int IDX_SCLK  = 0;
    localparam int IDX_DATA0 = 1;
    localparam int IDX_LOAD0 = IDX_DATA0 + NUM_CH;
    localparam int SYNC_W    = IDX_LOAD0 + NUM_CH;
endpackage

// File: rtl/dsr_sync.sv
module dsr_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] pipe;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.pipe[STAGES-1];
endmodule

// File: rtl/dsr_edge.sv
module dsr_edge #(
    parameter int WIDTH   = 1,
    parameter bit FALLING = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] edge_o
);
    typedef struct packed {
        logic [WIDTH-1:0] prev;
    } edge_t;

    edge_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        if (FALLING) begin : g_fall
            assign edge_o = ~level_i & st_q.prev;
        end else begin : g_rise
            assign edge_o = level_i & ~st_q.prev;
        end
    endgenerate
endmodule

// File: rtl/dsr_channel.sv
module dsr_channel #(
    parameter int WORD_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en_i,
    input  logic              bit_i,
    input  logic              load_i,
    output logic [WORD_W-1:0] code_o,
    output logic              upd_o
);
    typedef struct packed {
        logic [WORD_W-1:0] shift;
        logic [WORD_W-1:0] code;
        logic              upd;
    } chan_t;

    chan_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        if (load_i) begin
            st_d.code = st_q.shift;
            st_d.upd  = 1'b1;
        end
        if (shift_en_i) begin
            st_d.shift = {st_q.shift[WORD_W-2:0], bit_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code_o = st_q.code;
    assign upd_o  = st_q.upd;

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(st_q.code));

    assert_strobe_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.upd |=> !st_q.upd);

    assert_shift_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en_i |=> $stable(st_q.shift));

    assert_msb_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en_i |=> st_q.shift[WORD_W-1:1] == $past(st_q.shift[WORD_W-2:0]));
endmodule

// File: rtl/serial_dac_frontend.sv
module serial_dac_frontend #(
    parameter int WORD_W      = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              ldata_i,
    input  logic              rdata_i,
    input  logic              lload_n_i,
    input  logic              rload_n_i,
    output logic [WORD_W-1:0] lcode_o,
    output logic [WORD_W-1:0] rcode_o,
    output logic              lupd_o,
    output logic              rupd_o
);
    import dsr_pkg::*;

    logic [SYNC_W-1:0] raw_in;
    logic [SYNC_W-1:0] lvl;
    logic              sclk_rise;
    logic [NUM_CH-1:0] load_fall;
    logic [WORD_W-1:0] code   [NUM_CH];
    logic [NUM_CH-1:0] upd;

    always_comb begin
        raw_in                       = '0;
        raw_in[IDX_SCLK]             = sclk_i;
        raw_in[IDX_DATA0 + CH_LEFT]  = ldata_i;
        raw_in[IDX_DATA0 + CH_RIGHT] = rdata_i;
        raw_in[IDX_LOAD0 + CH_LEFT]  = lload_n_i;
        raw_in[IDX_LOAD0 + CH_RIGHT] = rload_n_i;
    end

    dsr_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(raw_in), .level_o(lvl));

    dsr_edge #(.WIDTH(1), .FALLING(1'b0)) u_sclk_edge (
        .clk(clk), .rst_n(rst_n), .level_i(lvl[IDX_SCLK]), .edge_o(sclk_rise));

    dsr_edge #(.WIDTH(NUM_CH), .FALLING(1'b1)) u_load_edge (
        .clk(clk), .rst_n(rst_n), .level_i(lvl[IDX_LOAD0 +: NUM_CH]), .edge_o(load_fall));

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            dsr_channel #(.WORD_W(WORD_W)) u_ch (
                .clk        (clk),
                .rst_n      (rst_n),
                .shift_en_i (sclk_rise),
                .bit_i      (lvl[IDX_DATA0 + c]),
                .load_i     (load_fall[c]),
                .code_o     (code[c]),
                .upd_o      (upd[c]));
        end
    endgenerate

    assign lcode_o = code[CH_LEFT];
    assign rcode_o = code[CH_RIGHT];
    assign lupd_o  = upd[CH_LEFT];
    assign rupd_o  = upd[CH_RIGHT];

    assert_shared_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_fall == '1) |=> (upd == '1));

    assert_isolated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_fall == NUM_CH'(1)) |=> (upd == NUM_CH'(1)));
endmodule

// File: tb/serial_dac_frontend_bench.sv
module serial_dac_frontend_bench;
    localparam int W = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, ld = 1'b0, rd = 1'b0, lload_n = 1'b1, rload_n = 1'b1;
    logic [W-1:0] lcode, rcode;
    logic lupd, rupd;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    int l_cyc = -1, r_cyc = -1;

    logic [W-1:0] m_sh [2];
    logic [W-1:0] m_out [2];

    bit           q_ch  [$];
    logic [W-1:0] q_val [$];
    string        q_tag [$];

    serial_dac_frontend u_serial_dac_frontend (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .ldata_i(ld), .rdata_i(rd),
        .lload_n_i(lload_n), .rload_n_i(rload_n),
        .lcode_o(lcode), .rcode_o(rcode), .lupd_o(lupd), .rupd_o(rupd));

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic pop_cmp(input bit ch, input logic [W-1:0] act);
        if (q_ch.size() == 0) begin
            check(1'b0, "R7 unexpected strobe", {63'd0, ch}, 64'd0);
        end else begin
            bit ech = q_ch.pop_front();
            logic [W-1:0] ev = q_val.pop_front();
            string t = q_tag.pop_front();
            check(ech == ch && act == ev, t, act, ev);
        end
    endtask

    // monitor: compares every produced update against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (lupd) begin l_cyc = cyc; pop_cmp(1'b0, lcode); end
            if (rupd) begin r_cyc = cyc; pop_cmp(1'b1, rcode); end
        end
    end

    task automatic send(input logic [63:0] lb, input logic [63:0] rb, input int n, input int half);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            sclk = 1'b0;
            ld = lb[i];
            rd = rb[i];
            repeat (half) @(negedge clk);
            sclk = 1'b1;
            m_sh[0] = {m_sh[0][W-2:0], lb[i]};
            m_sh[1] = {m_sh[1][W-2:0], rb[i]};
            repeat (half - 1) @(negedge clk);
        end
        @(negedge clk);
        sclk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_load(input bit l, input bit r, input int low_cyc, input string tag);
        int lat = -1;
        l_cyc = -1;
        r_cyc = -1;
        @(negedge clk);
        if (l) begin q_ch.push_back(1'b0); q_val.push_back(m_sh[0]); q_tag.push_back(tag); m_out[0] = m_sh[0]; end
        if (r) begin q_ch.push_back(1'b1); q_val.push_back(m_sh[1]); q_tag.push_back(tag); m_out[1] = m_sh[1]; end
        if (l) lload_n = 1'b0;
        if (r) rload_n = 1'b0;
        for (int k = 1; k <= low_cyc; k++) begin
            @(negedge clk);
            if (lat < 0 && (lupd || rupd)) lat = k;
        end
        lload_n = 1'b1;
        rload_n = 1'b1;
        repeat (8) @(negedge clk);
        check(lat == 3, "R10 load-to-strobe latency", lat, 3);
        if (l && r) check(l_cyc == r_cyc && l_cyc >= 0, "R6 shared load same cycle", l_cyc, r_cyc);
        check(q_ch.size() == 0, {tag, " update delivered"}, q_ch.size(), 0);
    endtask

    task automatic check_codes(input string tag);
        check(lcode == m_out[0], {tag, " left code"}, lcode, m_out[0]);
        check(rcode == m_out[1], {tag, " right code"}, rcode, m_out[1]);
    endtask

    initial begin
        m_sh[0] = '0; m_sh[1] = '0; m_out[0] = '0; m_out[1] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        // R1: midscale after reset, strobes low
        check(lcode == 18'h0 && rcode == 18'h0, "R1 reset codes midscale", {lcode, rcode}, 0);
        check(!lupd && !rupd, "R1 strobes low", {lupd, rupd}, 0);

        // R2 + R6: exact 18-bit words, shared load
        send(64'h2A5C3, 64'h1F00F, 18, 4);
        do_load(1'b1, 1'b1, 6, "R2 msb-first word");
        check_codes("R2");

        // R5: left-only load leaves right alone
        send(64'h3FFFF, 64'h15555, 18, 4);
        do_load(1'b1, 1'b0, 6, "R5 left only");
        check_codes("R5");
        check(rcode == 18'h1F00F, "R5 right unchanged", rcode, 18'h1F00F);

        // R3: 25 bits, only last 18 kept
        send(64'h1ABCDEF, 64'h0F0F0F3, 25, 4);
        do_load(1'b0, 1'b1, 6, "R3 long stream");
        check_codes("R3");
        check(rcode == 18'h0F0F3, "R3 last 18 bits", rcode, 18'h0F0F3);

        // R4: short word mixes old and new bits
        send(64'h20001, 64'h0, 18, 4);
        do_load(1'b1, 1'b0, 6, "R4 full word");
        send(64'h2D, 64'h0, 6, 4);
        do_load(1'b1, 1'b0, 6, "R4 short word");
        check(lcode == 18'h0006D, "R4 mixed code", lcode, 18'h0006D);

        // R6: shared data line, same word both sides
        send(64'h2468A, 64'h2468A, 18, 4);
        do_load(1'b1, 1'b1, 6, "R6 shared data");
        check(lcode == rcode && lcode == 18'h2468A, "R6 equal codes", lcode, rcode);

        // R7: long low pulse gives one strobe only, release gives none
        send(64'h11111, 64'h22222, 18, 4);
        do_load(1'b1, 1'b1, 30, "R7 long low load");
        check_codes("R7");

        // R8: data toggles with bit clock idle
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            ld = ~ld;
            rd = ~rd;
        end
        repeat (4) @(negedge clk);
        do_load(1'b1, 1'b1, 6, "R8 idle clock data");
        check(lcode == 18'h11111 && rcode == 18'h22222, "R8 code unchanged", {lcode, rcode}, {18'h11111, 18'h22222});

        // R9: fastest bit clock, 2 high / 2 low
        send(64'h35A5A, 64'h0C3C3, 18, 2);
        do_load(1'b1, 1'b1, 6, "R9 fast bit clock");
        check_codes("R9");

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule